// File: doc/BRIEF.md
# Timer Interrupt Mask and Lock-Once Prescaler

This block holds the control register of a 16-bit free-running timer. Four enable bits gate four status sources: the timer's own overflow, a real-time interrupt, a pulse-accumulator overflow and a pulse-accumulator edge. An interrupt request is raised when any enable bit and its paired flag are both set. The same register carries a two-bit prescaler select. The select sets the rate of the tick that advances the 16-bit counter. The counter and its overflow flag live inside the block. The other three flags come in as level inputs from neighbouring logic.

In normal mode the prescaler select is protected. Software may set it once, and only within the first 64 clock cycles after reset. After that it is frozen until the next reset. In special mode the select can be rewritten freely. The enable bits are writable at any time in either mode.

The bus port is a plain single-cycle write strobe with a 2-bit address and a combinational read path. The reset input is asynchronous and active-low. It must be released in step with the clock, so the first rising edge with `rst_n` high is bus cycle 0.

Top module: `tmr_mask_blk`

## Requirements
- R1: While reset is active and right after it is released, the control register reads 8'h00, the flag register reads 8'h00, the counter reads 16'h0000 and `irq` is 0.
- R2: Address 0 is the control register: bit 7 enables the overflow source, bit 6 the real-time source, bit 5 the accumulator-overflow source, bit 4 the accumulator-edge source, and bits 1:0 hold the prescaler select. Bits 3:2 always read 0, whatever is written.
- R3: Bits 7:4 of the control register take the written value on every write, in both modes, at any time.
- R4: In normal mode only the first write to address 0 that lands in the protection window updates bits 1:0. Every later write leaves them unchanged.
- R5: The protection window covers the rising edges on which the count of cycles since reset release is 0 through 63. A first write on cycle 63 is accepted. A first write on cycle 64 or later is ignored.
- R6: In special mode every write to address 0 updates bits 1:0, at any time and any number of times.
- R7: Select 00 gives one tick per clock, 01 one tick per 4 clocks, 10 one per 8 and 11 one per 16. The tick divider runs freely, so any 64 consecutive clocks hold exactly 64, 16, 8 or 4 ticks.
- R8: The counter advances by one on each tick. Address 2 reads its upper byte and address 3 its lower byte. A tick at 16'hFFFF wraps the counter to 16'h0000 and sets the overflow flag.
- R9: Address 1 is the flag register: bit 7 overflow, bit 6 real-time, bit 5 accumulator overflow, bit 4 accumulator edge, and bits 3:0 read 0. Writing 1 to bit 7 clears the overflow flag. Writing 0 leaves it set. If a wrap and a clear fall on the same edge, the flag stays set.
- R10: `irq` is a register loaded on each clock with the OR of the four enable/flag pairs. It follows a change in a flag or an enable one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| special_mode | input | 1 | 1 = special mode (select unprotected), 0 = normal mode |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 control, 1 flags, 2 counter high, 3 counter low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| rti_flag | input | 1 | Real-time interrupt status flag |
| pa_ovf_flag | input | 1 | Pulse-accumulator overflow status flag |
| pa_edge_flag | input | 1 | Pulse-accumulator edge status flag |
| irq | output | 1 | Combined, registered interrupt request |
| tick | output | 1 | Prescaled count enable for the 16-bit counter |

## Verification
A register write is visible on `bus_rdata` at the falling edge after the rising edge that captures it. An `irq` change is due one edge after the flag or enable that causes it. The bench therefore drives on a falling edge and reads on the next one, or one later for `irq`. The window tests count whole falling edges from reset release: waiting 63 of them puts the write on cycle 63, and waiting 64 puts it on cycle 64. The wrap test waits 65535 edges at divide-by-1, sees 16'hFFFF, and then expects 16'h0000 with the overflow bit one edge later. Tick rates are counted over 64 falling edges, with the counter read before and after the window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned FLAG_N = 4;
  localparam int unsigned DIV_W  = 4;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV8  = 2'b10,
    PS_DIV16 = 2'b11
  } ps_sel_e;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_FLAG   = 2'd1,
    A_CNT_HI = 2'd2,
    A_CNT_LO = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_prot_reg.sv
module tmr_prot_reg
  import tmr_pkg::*;
#(
  parameter int unsigned WINDOW = 64,
  localparam int unsigned CW = $clog2(WINDOW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                special_mode,
  input  logic                wr_ctrl,
  input  logic [7:0]          wdata,
  output logic [FLAG_N-1:0]   en_bits,
  output ps_sel_e             psel,
  output logic                wr_done,
  output logic [CW-1:0]       win_cnt
);
  localparam logic [CW-1:0] WIN_LIM = CW'(WINDOW);

  logic [CW-1:0]     cnt_d;
  logic              cnt_en;
  logic              in_win;
  logic              ps_ok;
  logic [FLAG_N-1:0] en_d;
  ps_sel_e           ps_d;
  logic              done_d;

  always_comb begin
    in_win = (win_cnt != WIN_LIM);
    cnt_en = in_win;
    cnt_d  = win_cnt + CW'(1);
    ps_ok  = wr_ctrl && (special_mode || (in_win && !wr_done));
    en_d   = wdata[7:4];
    ps_d   = ps_sel_e'(wdata[1:0]);
    done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (cnt_en) begin
      win_cnt <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bits <= '0;
    end else if (wr_ctrl) begin
      en_bits <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel    <= PS_DIV1;
      wr_done <= 1'b0;
    end else if (ps_ok) begin
      psel    <= ps_d;
      wr_done <= done_d;
    end
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ps_sel_e psel,
  output logic    tick
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    unique case (psel)
      PS_DIV1:  mask = DIV_W'(0);
      PS_DIV4:  mask = DIV_W'(3);
      PS_DIV8:  mask = DIV_W'(7);
      default:  mask = DIV_W'(15);
    endcase
    tick  = ((pre_q & mask) == mask);
    pre_d = pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;
  logic             ovf_d;
  logic             ovf_en;

  always_comb begin
    cnt_d  = cnt_val + CNT_W'(1);
    wrap   = tick && (cnt_val == {CNT_W{1'b1}});
    ovf_en = wrap || ovf_clr;
    ovf_d  = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val <= '0;
    end else if (tick) begin
      cnt_val <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (ovf_en) begin
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/tmr_mask_blk.sv
module tmr_mask_blk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned WINDOW = 64,
  localparam int unsigned CW = $clog2(WINDOW + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       special_mode,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rti_flag,
  input  logic       pa_ovf_flag,
  input  logic       pa_edge_flag,
  output logic       irq,
  output logic       tick
);
  logic [FLAG_N-1:0] en_bits;
  logic [FLAG_N-1:0] flag_vec;
  ps_sel_e           psel;
  logic              wr_done;
  logic [CW-1:0]     win_cnt;
  logic [CNT_W-1:0]  cnt_val;
  logic              ovf_q;
  logic              wr_ctrl;
  logic              ovf_clr;
  logic              irq_d;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    ovf_clr  = bus_wr && (bus_addr == A_FLAG) && bus_wdata[7];
    flag_vec = {ovf_q, rti_flag, pa_ovf_flag, pa_edge_flag};
    irq_d    = |(en_bits & flag_vec);
  end

  tmr_prot_reg #(.WINDOW(WINDOW)) u_prot (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_ctrl      (wr_ctrl),
    .wdata        (bus_wdata),
    .en_bits      (en_bits),
    .psel         (psel),
    .wr_done      (wr_done),
    .win_cnt      (win_cnt)
  );

  tmr_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .psel  (psel),
    .tick  (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ovf_clr (ovf_clr),
    .cnt_val (cnt_val),
    .ovf_q   (ovf_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:   bus_rdata = {en_bits, 2'b00, psel};
      A_FLAG:   bus_rdata = {flag_vec, 4'b0000};
      A_CNT_HI: bus_rdata = 8'(cnt_val >> 8);
      default:  bus_rdata = cnt_val[7:0];
    endcase
  end
endmodule

// File: rtl/tmr_mask_chk.sv
module tmr_mask_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned WINDOW = 64,
  localparam int unsigned CW = $clog2(WINDOW + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             special_mode,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             irq,
  input logic [3:0]       en_bits,
  input logic [3:0]       flag_vec,
  input logic [1:0]       psel,
  input logic             wr_done,
  input logic [CW-1:0]    win_cnt,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ovf_q
);
  localparam logic [CW-1:0] WIN_LIM = CW'(WINDOW);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[3:2] == 2'b00));

  p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && wr_done) |=> $stable(psel));

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && win_cnt == WIN_LIM) |=> $stable(psel));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_val));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_val == {CNT_W{1'b1}}) |=> (cnt_val == '0 && ovf_q));

  p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(en_bits & flag_vec))));
endmodule

bind tmr_mask_blk tmr_mask_chk #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .special_mode (special_mode),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .irq          (irq),
  .en_bits      (en_bits),
  .flag_vec     (flag_vec),
  .psel         (psel),
  .wr_done      (wr_done),
  .win_cnt      (win_cnt),
  .tick         (tick),
  .cnt_val      (cnt_val),
  .ovf_q        (ovf_q)
);

// File: tb/sim_tmr_mask_blk.sv
`timescale 1ns/100ps
module sim_tmr_mask_blk;
  logic       clk;
  logic       rst_n;
  logic       special_mode;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       rti_flag;
  logic       pa_ovf_flag;
  logic       pa_edge_flag;
  logic       irq;
  logic       tick;

  int n_chk;
  int n_err;
  int cyc;

  tmr_mask_blk u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .rti_flag     (rti_flag),
    .pa_ovf_flag  (pa_ovf_flag),
    .pa_edge_flag (pa_edge_flag),
    .irq          (irq),
    .tick         (tick)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] hi;
    logic [7:0] lo;
    rd(2'd2, hi);
    rd(2'd3, lo);
    v = {hi, lo};
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_reset(input logic spec);
    @(negedge clk);
    rst_n = 1'b0;
    special_mode = spec;
    bus_wr = 1'b0;
    bus_addr = 2'd0;
    bus_wdata = 8'h00;
    rti_flag = 1'b0;
    pa_ovf_flag = 1'b0;
    pa_edge_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] c;
    do_reset(1'b0);
    rd(2'd0, d);  check("R1 ctrl", d, 8'h00);
    rd(2'd1, d);  check("R1 flags", d, 8'h00);
    rd_cnt(c);    check("R1 count", c, 16'h0000);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_normal_lock;
    logic [7:0] d;
    do_reset(1'b0);
    wr(2'd0, 8'hFF);
    rd(2'd0, d);  check("R2 reserved bits zero", d, 8'hF3);
    wr(2'd0, 8'h00);
    rd(2'd0, d);  check("R4 second write ignored, R3 enables cleared", d, 8'h03);
    wr(2'd0, 8'hA2);
    rd(2'd0, d);  check("R3 enables written, R4 select kept", d, 8'hA3);
  endtask

  task automatic t_window;
    logic [7:0] d;
    do_reset(1'b0);
    repeat (63) @(negedge clk);
    wr(2'd0, 8'h02);
    rd(2'd0, d);  check("R5 write on cycle 63 accepted", d, 8'h02);
    do_reset(1'b0);
    repeat (64) @(negedge clk);
    wr(2'd0, 8'h51);
    rd(2'd0, d);  check("R5 write on cycle 64 ignored", d, 8'h50);
  endtask

  task automatic t_special;
    logic [7:0] d;
    do_reset(1'b1);
    repeat (100) @(negedge clk);
    wr(2'd0, 8'h01);
    rd(2'd0, d);  check("R6 late write 1", d, 8'h01);
    wr(2'd0, 8'h12);
    rd(2'd0, d);  check("R6 late write 2", d, 8'h12);
    wr(2'd0, 8'h03);
    rd(2'd0, d);  check("R6 late write 3", d, 8'h03);
  endtask

  task automatic t_prescale;
    logic [15:0] c0;
    logic [15:0] c1;
    int ticks;
    int divs [4] = '{1, 4, 8, 16};
    do_reset(1'b1);
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 8'(s));
      rd_cnt(c0);
      ticks = 0;
      for (int k = 0; k < 64; k++) begin
        if (tick) ticks++;
        @(negedge clk);
      end
      rd_cnt(c1);
      check($sformatf("R7 ticks for select %0d", s), ticks, 64 / divs[s]);
      check($sformatf("R8 count step for select %0d", s), 32'(c1 - c0), 64 / divs[s]);
    end
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    logic [15:0] c;
    do_reset(1'b1);
    repeat (65535) @(negedge clk);
    rd_cnt(c);    check("R8 count at top", c, 16'hFFFF);
    rd(2'd1, d);  check("R8 no flag before wrap", d, 8'h00);
    @(negedge clk);
    rd_cnt(c);    check("R8 count wrapped", c, 16'h0000);
    rd(2'd1, d);  check("R8 overflow flag set", d, 8'h80);
    wr(2'd1, 8'h00);
    rd(2'd1, d);  check("R9 write 0 keeps flag", d, 8'h80);
    wr(2'd1, 8'h80);
    rd(2'd1, d);  check("R9 write 1 clears flag", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    do_reset(1'b0);
    wr(2'd0, 8'h40);
    rti_flag = 1'b1;
    #0.2;
    check("R10 irq not yet", irq, 1'b0);
    rd(2'd1, d);  check("R9 real-time flag at bit 6", d, 8'h40);
    @(negedge clk);
    check("R10 irq one edge after flag", irq, 1'b1);
    rti_flag = 1'b0;
    pa_edge_flag = 1'b1;
    @(negedge clk);
    check("R10 masked source gives no irq", irq, 1'b0);
    wr(2'd0, 8'h10);
    check("R10 irq one edge after enable", irq, 1'b0);
    @(negedge clk);
    check("R10 irq from edge source", irq, 1'b1);
    pa_edge_flag = 1'b0;
    pa_ovf_flag = 1'b1;
    wr(2'd0, 8'h20);
    @(negedge clk);
    check("R10 irq from accumulator overflow", irq, 1'b1);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    special_mode = 1'b0;
    bus_wr = 1'b0;
    bus_addr = 2'd0;
    bus_wdata = 8'h00;
    rti_flag = 1'b0;
    pa_ovf_flag = 1'b0;
    pa_edge_flag = 1'b0;
    t_reset();
    t_normal_lock();
    t_window();
    t_special();
    t_prescale();
    t_wrap();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end
endmodule